// File: doc/BRIEF.md
# XOR-Swizzled Transposing Tile Buffer

This block holds one square tile of 32-bit words (32 x 32 by default) spread over as many word-wide banks as the tile has lanes. Each cycle it can accept one vector written as a *column* of the logical tile and return one vector read as a *row*. Lane `i` of a write lands at logical (row `i`, column `wr_col`), and lane `j` of a read comes from logical (row `rd_row`, column `j`). Writing incoming row vectors as columns therefore hands back the transpose.

A plain row-major layout would send every lane of a column write to the same bank. The default placement avoids this by permuting the column index with an XOR against the row index. The word for logical (r, c) sits at physical offset `r*T + (c ^ r)`, in bank `(c ^ r) mod T`. For a fixed column or a fixed row the XOR is a bijection over the lanes, so both access shapes touch every bank once. A second placement, selected by `mode_pad`, uses a row stride of T+1 for comparison. It gives bank `(r + c) mod T` and leaves one word per row unused.

Lanes whose source element lies outside the matrix are flagged low on `wr_keep` and stored as zero. A read issued in the same cycle as a write sees that write. The `conflict` output is a live self-check that rises if any single access would use one bank twice. The mode must be held constant while a tile is live, because the two placements store a given element at different words.

Top module: `swz_tile_buf`

## Requirements
- R1: A write with `wr_en`=1 stores lane i of `wr_data` (bits i*32 +: 32) at logical (row i, column `wr_col`). A read of row r returns logical (r, j) on lane j of `rd_data`, so a tile written column by column reads back transposed.
- R2: `rd_data` and `rd_valid`=1 appear on the clock cycle after the one in which `rd_en`=1 is sampled. `rd_valid` is 0 after a cycle without `rd_en`, and `rd_data` then keeps its last value.
- R3: With `mode_pad`=0, logical (r, c) lives at physical word r*32 + (c XOR r), in bank (c XOR r) mod 32. Every column write and row read uses all 32 banks exactly once, and data round-trips exactly.
- R4: With `mode_pad`=1, logical (r, c) lives at word r*33 + c, in bank (r + c) mod 32, using 33 words per bank. Every access again uses all banks exactly once, and data round-trips exactly.
- R5: A write lane whose `wr_keep` bit is 0 stores zero at its logical position, whatever its `wr_data` lane holds.
- R6: `conflict` is 1 exactly when the current write or read maps two lanes to one bank. In both placements it stays 0 for every column and row index.
- R7: When a read and a write are sampled in the same cycle, the read reflects the write. Lane `wr_col` of the result is the written lane `rd_row` (zero if that lane's keep bit is 0), and the other lanes come from storage.
- R8: While `rst_n` is 0 and right after it, `rd_valid` is 0, `rd_data` is all zero and `conflict` is 0.
- R9: A cycle with `wr_en`=0 changes no stored word, whatever `wr_col`, `wr_keep` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pad | input | 1 | 0: XOR placement, 1: stride-33 padded placement |
| wr_en | input | 1 | Write one logical column this cycle |
| wr_col | input | 5 | Logical column written |
| wr_keep | input | 32 | Per lane: 1 store data, 0 store zero |
| wr_data | input | 1024 | Write lanes, lane i at bits i*32 +: 32 |
| rd_en | input | 1 | Read one logical row this cycle |
| rd_row | input | 5 | Logical row read |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |
| rd_data | output | 1024 | Read lanes, lane j at bits j*32 +: 32 |
| conflict | output | 1 | Current access maps two lanes to one bank |

## Verification
The hardest case to reach from the ports is the single element shared by a write column and a read row in the same cycle. It is the only word whose stored copy is stale when the banks are read, so the result depends entirely on the bypass path. The stimulus first fills the whole tile with position-coded values, then issues a write and a read together. This is done in both placements, once with the shared lane kept and once with it masked to zero. The bench then checks that the crossing lane alone shows the new value and that a later read sees the full new column. Bank spreading itself is not visible as data, so each placement is filled and drained completely under several bound masks. A wrong bank or word mapping then shows up as an overwritten or misplaced element.

// File: rtl/swz_tile_pkg.sv
package swz_tile_pkg;

  // Physical word offset of logical (row, col) in a tile of side `tile`.
  // XOR placement needs `tile` to be a power of two.
  function automatic int unsigned phys_word(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned tile,
                                            input logic        pad);
    if (pad) return row * (tile + 1) + col;
    return row * tile + (col ^ row);
  endfunction

  function automatic int unsigned word_bank(input int unsigned word,
                                            input int unsigned tile);
    return word % tile;
  endfunction

  function automatic int unsigned word_slot(input int unsigned word,
                                            input int unsigned tile);
    return word / tile;
  endfunction

endpackage

// File: rtl/swz_lane_map.sv
module swz_lane_map
  import swz_tile_pkg::*;
#(
  parameter int TILE = 32,
  parameter int LW   = $clog2(TILE),
  parameter int IW   = $clog2(TILE + 1)
) (
  input  logic          pad,
  input  logic          col_fixed,   // 1: fixed column, lane = row
  input  logic [LW-1:0] fixed,
  output logic [LW-1:0] lane_bank [TILE],
  output logic [TILE-1:0] bank_hit,
  output logic [LW-1:0] bank_lane [TILE],
  output logic [IW-1:0] bank_slot [TILE],
  output logic          clash
);
  logic [IW-1:0] lane_slot [TILE];

  for (genvar i = 0; i < TILE; i++) begin : g_lane
    localparam int unsigned LANE = i;
    int unsigned row_i, col_i, word_i;
    assign row_i  = col_fixed ? LANE : int'(fixed);
    assign col_i  = col_fixed ? int'(fixed) : LANE;
    assign word_i = phys_word(row_i, col_i, TILE, pad);
    assign lane_bank[i] = LW'(word_bank(word_i, TILE));
    assign lane_slot[i] = IW'(word_slot(word_i, TILE));
  end

  // Invert lane->bank and flag any bank claimed twice.
  always_comb begin
    bank_hit = '0;
    clash    = 1'b0;
    for (int b = 0; b < TILE; b++) begin
      bank_lane[b] = '0;
      bank_slot[b] = '0;
    end
    for (int i = 0; i < TILE; i++) begin
      if (bank_hit[lane_bank[i]]) clash = 1'b1;
      bank_hit[lane_bank[i]]  = 1'b1;
      bank_lane[lane_bank[i]] = LW'(i);
      bank_slot[lane_bank[i]] = lane_slot[i];
    end
  end
endmodule

// File: rtl/swz_bank.sv
module swz_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 33,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/swz_tile_buf.sv
module swz_tile_buf #(
  parameter int TILE = 32,
  parameter int DW   = 32,
  localparam int LW    = $clog2(TILE),
  localparam int DEPTH = TILE + 1,
  localparam int IW    = $clog2(DEPTH),
  localparam int VW    = TILE * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pad,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_col,
  input  logic [TILE-1:0] wr_keep,
  input  logic [VW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [LW-1:0] rd_row,
  output logic          rd_valid,
  output logic [VW-1:0] rd_data,
  output logic          conflict
);
  logic [LW-1:0]   w_lane_bank [TILE];
  logic [TILE-1:0] w_bank_hit;
  logic [LW-1:0]   w_bank_lane [TILE];
  logic [IW-1:0]   w_bank_slot [TILE];
  logic            w_clash;
  logic [LW-1:0]   r_lane_bank [TILE];
  logic [TILE-1:0] r_bank_hit;
  logic [LW-1:0]   r_bank_lane [TILE];
  logic [IW-1:0]   r_bank_slot [TILE];
  logic            r_clash;

  // Named events for the checker
  logic [TILE-1:0] bank_we, bank_re;

  logic [DW-1:0] wr_lane [TILE];
  logic [DW-1:0] bank_q  [TILE];
  logic [LW-1:0] rsel    [TILE];
  logic          fwd_hit;
  logic [LW-1:0] fwd_lane;
  logic [DW-1:0] fwd_val;

  swz_lane_map #(.TILE(TILE), .LW(LW), .IW(IW)) u_wmap (
    .pad(mode_pad), .col_fixed(1'b1), .fixed(wr_col),
    .lane_bank(w_lane_bank), .bank_hit(w_bank_hit),
    .bank_lane(w_bank_lane), .bank_slot(w_bank_slot), .clash(w_clash));

  swz_lane_map #(.TILE(TILE), .LW(LW), .IW(IW)) u_rmap (
    .pad(mode_pad), .col_fixed(1'b0), .fixed(rd_row),
    .lane_bank(r_lane_bank), .bank_hit(r_bank_hit),
    .bank_lane(r_bank_lane), .bank_slot(r_bank_slot), .clash(r_clash));

  for (genvar i = 0; i < TILE; i++) begin : g_keep
    assign wr_lane[i] = wr_keep[i] ? wr_data[i*DW +: DW] : '0;
  end

  for (genvar b = 0; b < TILE; b++) begin : g_bank
    assign bank_we[b] = wr_en & w_bank_hit[b];
    assign bank_re[b] = rd_en & r_bank_hit[b];
    swz_bank #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[b]), .widx(w_bank_slot[b]), .wdata(wr_lane[w_bank_lane[b]]),
      .re(bank_re[b]), .ridx(r_bank_slot[b]), .rdata(bank_q[b]));
  end

  // Read-side lane routing and same-cycle write bypass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      fwd_hit  <= 1'b0;
      fwd_lane <= '0;
      fwd_val  <= '0;
      for (int j = 0; j < TILE; j++) rsel[j] <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        fwd_hit  <= wr_en;
        fwd_lane <= wr_col;
        fwd_val  <= wr_lane[rd_row];
        for (int j = 0; j < TILE; j++) rsel[j] <= r_lane_bank[j];
      end
    end
  end

  for (genvar j = 0; j < TILE; j++) begin : g_out
    assign rd_data[j*DW +: DW] = (fwd_hit && fwd_lane == LW'(j)) ? fwd_val
                                                                 : bank_q[rsel[j]];
  end

  assign conflict = (wr_en & w_clash) | (rd_en & r_clash);
endmodule

// File: rtl/swz_tile_buf_chk.sv
module swz_tile_buf_chk #(
  parameter int TILE = 32,
  parameter int DW   = 32,
  localparam int LW  = $clog2(TILE),
  localparam int VW  = TILE * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_pad,
  input logic          wr_en,
  input logic [LW-1:0] wr_col,
  input logic [TILE-1:0] wr_keep,
  input logic [VW-1:0] wr_data,
  input logic          rd_en,
  input logic [LW-1:0] rd_row,
  input logic          rd_valid,
  input logic [VW-1:0] rd_data,
  input logic          conflict,
  input logic [TILE-1:0] bank_we,
  input logic [TILE-1:0] bank_re
);
  logic [DW-1:0] exp_fwd, fwd_exp_q;
  logic [LW-1:0] fwd_col_q;
  logic          fwd_arm;

  always_comb exp_fwd = wr_keep[rd_row] ? wr_data[rd_row*DW +: DW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_arm   <= 1'b0;
      fwd_col_q <= '0;
      fwd_exp_q <= '0;
    end else begin
      fwd_arm   <= wr_en && rd_en;
      fwd_col_q <= wr_col;
      fwd_exp_q <= exp_fwd;
    end
  end

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid) else $error("rd_valid missing");                 // R2
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid) else $error("rd_valid spurious");              // R2
  AST_XOR_WR_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_pad) |-> bank_we == {TILE{1'b1}}) else $error("xor wr");  // R3
  AST_XOR_RD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mode_pad) |-> bank_re == {TILE{1'b1}}) else $error("xor rd");  // R3
  AST_PAD_WR_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_pad) |-> bank_we == {TILE{1'b1}}) else $error("pad wr");   // R4
  AST_PAD_RD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode_pad) |-> bank_re == {TILE{1'b1}}) else $error("pad rd");   // R4
  AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict) else $error("bank clash");                                // R6
  AST_FWD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_arm |-> rd_data[fwd_col_q*DW +: DW] == fwd_exp_q) else $error("bypass");  // R7
  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |=> !rd_valid) else $error("valid in reset");                 // R8
  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> bank_we == '0) else $error("idle write");                 // R9
endmodule

bind swz_tile_buf swz_tile_buf_chk #(.TILE(TILE), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pad(mode_pad), .wr_en(wr_en),
  .wr_col(wr_col), .wr_keep(wr_keep), .wr_data(wr_data), .rd_en(rd_en),
  .rd_row(rd_row), .rd_valid(rd_valid), .rd_data(rd_data),
  .conflict(conflict), .bank_we(bank_we), .bank_re(bank_re));

// File: tb/swz_tile_buf_tb.sv
module swz_tile_buf_tb;
  localparam int T  = 32;
  localparam int DW = 32;
  localparam int VW = T * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_pad = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_col = '0, rd_row = '0;
  logic [T-1:0] wr_keep = '0;
  logic [VW-1:0] wr_data = '0;
  logic rd_valid, conflict;
  logic [VW-1:0] rd_data;

  always #4 clk = ~clk;

  swz_tile_buf u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit conf_seen = 1'b0;
  logic [DW-1:0] model [T][T];   // model[row][col]

  always @(posedge clk) if (rst_n && conflict) conf_seen = 1'b1;

  // {mode_pad, seed[15:0], row_limit[5:0], col_limit[5:0]}
  localparam logic [28:0] TAB [8] = '{
    {1'b0, 16'hA001, 6'd32, 6'd32},
    {1'b1, 16'hB002, 6'd32, 6'd32},
    {1'b0, 16'hC003, 6'd20, 6'd32},
    {1'b1, 16'hD004, 6'd32, 6'd7},
    {1'b0, 16'hE005, 6'd1,  6'd1},
    {1'b1, 16'h1F06, 6'd31, 6'd17},
    {1'b0, 16'h2A07, 6'd0,  6'd32},
    {1'b1, 16'h3B08, 6'd32, 6'd0}
  };

  function automatic logic [31:0] val(logic [15:0] s, int r, int c);
    return {s, 3'b000, 5'(r), 3'b000, 5'(c)};
  endfunction

  task automatic chk_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] row_vec(int r);
    logic [VW-1:0] v;
    for (int j = 0; j < T; j++) v[j*DW +: DW] = model[r][j];
    return v;
  endfunction

  // Drive a column write (and optionally a read) for one cycle.
  task automatic drive(bit do_wr, int c, logic [15:0] s, logic [T-1:0] keep,
                       bit do_rd, int r);
    wr_en = do_wr; wr_col = 5'(c); wr_keep = keep; rd_en = do_rd; rd_row = 5'(r);
    for (int i = 0; i < T; i++) wr_data[i*DW +: DW] = val(s, i, c);
    if (do_wr)
      for (int i = 0; i < T; i++) model[i][c] = keep[i] ? val(s, i, c) : '0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic read_row(int r, string tag);
    drive(1'b0, 0, 16'h0, '0, 1'b1, r);
    chk_bit({tag, " valid"}, rd_valid, 1'b1);
    chk_vec(tag, rd_data, row_vec(r));
  endtask

  task automatic fill(logic [15:0] s, int rl, int cl);
    for (int c = 0; c < T; c++) begin
      logic [T-1:0] k;
      for (int i = 0; i < T; i++) k[i] = (i < rl) && (c < cl);
      drive(1'b1, c, s, k, 1'b0, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_bit("R8 rd_valid in reset", rd_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R8 rd_valid after reset", rd_valid, 1'b0);
    chk_vec("R8 rd_data after reset", rd_data, '0);
    chk_bit("R8 conflict after reset", conflict, 1'b0);

    // Table walk: fill whole tile as columns, drain as rows.
    for (int e = 0; e < 8; e++) begin
      mode_pad = TAB[e][28];
      fill(TAB[e][27:12], int'(TAB[e][11:6]), int'(TAB[e][5:0]));
      for (int r = 0; r < T; r++)
        read_row(r, TAB[e][28] ? "R1 R4 R5 padded row" : "R1 R3 R5 xor row");
    end

    // R2: idle cycle drops valid and holds data
    mode_pad = 1'b0;
    fill(16'h5150, 32, 32);
    read_row(13, "R2 read");
    @(negedge clk);
    chk_bit("R2 valid idle", rd_valid, 1'b0);
    chk_vec("R2 data held", rd_data, row_vec(13));

    // R9: write strobe low, garbage on write inputs
    wr_en = 1'b0; wr_col = 5'd3; wr_keep = '1; wr_data = '1;
    @(negedge clk);
    wr_data = '0;
    read_row(0, "R9 ignored write row0");
    read_row(31, "R9 ignored write row31");

    // R7: same-cycle write and read, both placements
    for (int m = 0; m < 2; m++) begin
      logic [T-1:0] k;
      mode_pad = m[0];
      fill(16'h7700 + 16'(m), 32, 32);
      k = '1;
      if (m == 1) k[9] = 1'b0;   // masked crossing lane forwards zero (R5)
      drive(1'b1, 5, 16'h9900 + 16'(m), k, 1'b1, 9);
      chk_vec(m ? "R7 R5 padded bypass" : "R7 xor bypass", rd_data, row_vec(9));
      read_row(9, "R7 later read row9");
      read_row(4, "R7 later read row4");
    end

    chk_bit("R6 conflict never seen", conf_seen, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule